// File: doc/BRIEF.md
# DVFS Level Transition Sequencer

This block moves a processor clock domain between four performance levels. Level 0 is the fastest (1000 MHz), followed by level 1 (800 MHz), level 2 (400 MHz) and level 3 (100 MHz). A requester asks for a target level. The sequencer compares it with the level in force and then orders three kinds of action against the clock and power hardware:

- a request to the supply regulators for new core and internal rail voltages;
- a write to the divider banks;
- a rewrite of the core PLL configuration.

When level 0 is the source or the target, the PLL is fully relocked. During the relock the core clock mux is moved to an alternate PLL. Every other move rewrites only the post-divider field of the PLL word.

The order of the steps follows the direction of the move. When speeding up, the voltage is raised first, then the dividers are written, then the PLL is changed. When slowing down, the PLL is changed first, then the dividers are written, and the voltage is lowered last.

The request side uses a valid/ready pair. `req_ready` is high only while the sequencer is idle, and a request is taken in a cycle where `req_valid` and `req_ready` are both high. While ready is low, valid is ignored, and no request is queued. The voltage port is a valid/ready producer. `vset_valid` stays high, with stable values, until `vset_ready` is seen. Each wait for an external condition is bounded by `tmo_cycles`.

Top module: `dvfs_seq`

## Requirements
- R1: After reset the block is in the following state:
  - `req_ready` is 1; `err`, `done`, `mux_alt`, `div_wr`, `pll_wr`, `lt_wr` and `vset_valid` are 0;
  - `cur_level` equals the reset level parameter;
  - `pll_cfg` and the voltage outputs hold that level's values.
- R2: `req_ready` is 1 exactly while idle, and a request is accepted on `req_valid && req_ready`. While `req_ready` is 0, `req_valid` changes no output, no action and not the final `cur_level`.
- R3: A request for the level already in force causes no voltage, divider, PLL or mux activity. `done` pulses in the cycle after acceptance, and `pll_cfg` is unchanged.
- R4: For a faster target (a lower index), the voltage handshake completes before the divider write. The divider busy then clears before any PLL action.
- R5: For a slower target, the PLL action completes first. The divider write and its busy clearing come next, and the voltage handshake is last, before `done`.
- R6: The target voltages in mV (core/internal) are 1200/1100 for L0, 1100/1100 for L1, 1000/1000 for L2 and 900/1000 for L3. `vset_valid` holds with stable values until `vset_ready`.
- R7: A move from or to L0 runs the following relock, in this order:
  - `mux_alt` rises;
  - the sequencer waits for `mux_stat` == 2;
  - `lt_wr` pulses with `lt_value`;
  - `pll_wr` pulses with the full target word;
  - the sequencer waits for `pll_lock`;
  - `mux_alt` falls;
  - the sequencer waits for `mux_stat` == 1.
- R8: Any other level change issues one `pll_wr` in which only bits [2:0] of `pll_cfg` change. Bits [25:8] keep their values and `mux_alt` stays 0.
- R9: `pll_cfg` holds M in [25:16], P in [13:8] and S in [2:0], with all other bits 0. The (M,P,S) values are (250,6,1) for L0, (200,6,1) for L1, (200,6,2) for L2 and (200,6,4) for L3.
- R10: `done` is a one-cycle pulse at the end of a move, and `cur_level` shows the target from the next cycle on.
- R11: If a wait is still unmet after `tmo_cycles`+1 cycles in that state, the move is abandoned. This covers the voltage ready, divider busy, mux status and PLL lock waits. `err` then goes to 1 and stays there until reset. The sequencer returns to idle without `done`, and `cur_level` is unchanged.
- R12: `div_wr` is a one-cycle strobe with `div_level` equal to the target level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_cycles | input | CNT_W | Wait limit for every wait state |
| req_valid | input | 1 | Level request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_level | input | 2 | Requested level, 0 fastest |
| done | output | 1 | One-cycle end-of-move acknowledge |
| cur_level | output | 2 | Level currently in force |
| err | output | 1 | Sticky timeout flag |
| vset_valid | output | 1 | Voltage request valid |
| vset_ready | input | 1 | Regulators accepted and settled |
| vset_arm_mv | output | 11 | Core rail target, mV |
| vset_int_mv | output | 11 | Internal rail target, mV |
| div_wr | output | 1 | Divider bank write strobe |
| div_level | output | 2 | Level whose divider set is written |
| div_busy | input | 1 | Divider change in progress |
| pll_cfg | output | 32 | PLL configuration word |
| pll_wr | output | 1 | PLL configuration write strobe |
| lt_wr | output | 1 | Lock time load strobe |
| lt_value | output | LT_W | Lock time value |
| pll_lock | input | 1 | PLL locked |
| mux_alt | output | 1 | Core mux on alternate PLL |
| mux_stat | input | 3 | Mux status: 1 main, 2 alternate |

## Verification
The bench builds the sequencer with the slowest level as the reset level, an 8-bit timeout counter and a 16-bit lock time. It drives `tmo_cycles` at 50 for normal moves and at 20 for the fault case. With these values, a move from the slowest level to the fastest and back is reachable from reset. A stuck lock runs out its timeout within a few dozen cycles, so the sticky error path is reached cheaply. Regulator, divider, PLL and mux responders have fixed latencies. Those latencies make every wait state hold for several cycles, which exposes the ordering of the voltage, divider and PLL steps.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  localparam int LVL_W = 2;
  localparam int MV_W  = 11;
  localparam int CFG_W = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VOLT,
    ST_DIV_WR,
    ST_DIV_WAIT,
    ST_S_WR,
    ST_WAIT_ALT,
    ST_LT_WR,
    ST_PMS_WR,
    ST_WAIT_LOCK,
    ST_WAIT_MAIN,
    ST_FINISH
  } seq_st_t;

  function automatic logic [9:0] lvl_mul(input logic [LVL_W-1:0] l);
    return (l == '0) ? 10'd250 : 10'd200;
  endfunction

  function automatic logic [5:0] lvl_pre(input logic [LVL_W-1:0] l);
    return (l == '0) ? 6'd6 : 6'd6;
  endfunction

  function automatic logic [2:0] lvl_post(input logic [LVL_W-1:0] l);
    case (l)
      2'd2:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [MV_W-1:0] lvl_arm_mv(input logic [LVL_W-1:0] l);
    case (l)
      2'd0:    return 11'd1200;
      2'd1:    return 11'd1100;
      2'd2:    return 11'd1000;
      default: return 11'd900;
    endcase
  endfunction

  function automatic logic [MV_W-1:0] lvl_int_mv(input logic [LVL_W-1:0] l);
    return (l < 2'd2) ? 11'd1100 : 11'd1000;
  endfunction

  function automatic logic [CFG_W-1:0] lvl_word(input logic [LVL_W-1:0] l);
    logic [CFG_W-1:0] w;
    w = '0;
    w[25:16] = lvl_mul(l);
    w[13:8]  = lvl_pre(l);
    w[2:0]   = lvl_post(l);
    return w;
  endfunction

  // First state of a clock step: divider write, full relock or post-divider rewrite
  function automatic seq_st_t step_entry(input logic div_now, input logic full_relock);
    if (div_now)          return ST_DIV_WR;
    else if (full_relock) return ST_WAIT_ALT;
    else                  return ST_S_WR;
  endfunction

endpackage

// File: rtl/dvfs_lvl_tab.sv
module dvfs_lvl_tab
  import dvfs_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  output logic [CFG_W-1:0] word,
  output logic [2:0]       post,
  output logic [MV_W-1:0]  arm_mv,
  output logic [MV_W-1:0]  int_mv
);
  always_comb begin
    word   = lvl_word(lvl);
    post   = lvl_post(lvl);
    arm_mv = lvl_arm_mv(lvl);
    int_mv = lvl_int_mv(lvl);
  end
endmodule

// File: rtl/dvfs_tmo.sv
module dvfs_tmo #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart)              cnt <= '0;
    else if (run && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int RST_LEVEL = 3,
  parameter int CNT_W     = 16,
  parameter int LT_W      = 16,
  parameter int LT_VAL    = 270
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmo_cycles,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_level,
  output logic             done,
  output logic [1:0]       cur_level,
  output logic             err,
  output logic             vset_valid,
  input  logic             vset_ready,
  output logic [10:0]      vset_arm_mv,
  output logic [10:0]      vset_int_mv,
  output logic             div_wr,
  output logic [1:0]       div_level,
  input  logic             div_busy,
  output logic [31:0]      pll_cfg,
  output logic             pll_wr,
  output logic             lt_wr,
  output logic [LT_W-1:0]  lt_value,
  input  logic             pll_lock,
  output logic             mux_alt,
  input  logic [2:0]       mux_stat
);
  localparam logic [LVL_W-1:0] RST_LVL  = LVL_W'(RST_LEVEL);
  localparam logic [2:0]       STAT_MAIN = 3'd1;
  localparam logic [2:0]       STAT_ALT  = 3'd2;

  seq_st_t          state, nxt;
  logic [LVL_W-1:0] cur, tgt, src;
  logic             up, stage;
  logic             mux_q, err_q;
  logic [CFG_W-1:0] cfg_q;
  logic [MV_W-1:0]  arm_q, int_q;

  logic             step_done, abort, expired, in_wait;
  logic             full, req_full;
  logic [LVL_W-1:0] tab_lvl;
  logic [CFG_W-1:0] tab_word;
  logic [2:0]       tab_post;
  logic [MV_W-1:0]  tab_arm, tab_int;

  assign tab_lvl = (state == ST_IDLE) ? req_level : tgt;

  dvfs_lvl_tab u_tab (
    .lvl    (tab_lvl),
    .word   (tab_word),
    .post   (tab_post),
    .arm_mv (tab_arm),
    .int_mv (tab_int)
  );

  assign in_wait = (state == ST_VOLT) || (state == ST_DIV_WAIT) ||
                   (state == ST_WAIT_ALT) || (state == ST_WAIT_LOCK) ||
                   (state == ST_WAIT_MAIN);

  dvfs_tmo #(.CNT_W(CNT_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (nxt != state),
    .run     (in_wait),
    .limit   (tmo_cycles),
    .expired (expired)
  );

  assign full     = (src == '0) || (tgt == '0);
  assign req_full = (cur == '0) || (req_level == '0);

  always_comb begin
    nxt       = state;
    step_done = 1'b0;
    abort     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_level == cur)     nxt = ST_FINISH;
          else if (req_level < cur) nxt = ST_VOLT;
          else                      nxt = step_entry(1'b0, req_full);
        end
      end
      ST_VOLT: begin
        if (vset_ready) nxt = up ? step_entry(1'b1, full) : ST_FINISH;
        else if (expired) abort = 1'b1;
      end
      ST_DIV_WR:   nxt = ST_DIV_WAIT;
      ST_DIV_WAIT: begin
        if (!div_busy)    step_done = 1'b1;
        else if (expired) abort = 1'b1;
      end
      ST_S_WR:     step_done = 1'b1;
      ST_WAIT_ALT: begin
        if (mux_stat == STAT_ALT) nxt = ST_LT_WR;
        else if (expired)         abort = 1'b1;
      end
      ST_LT_WR:    nxt = ST_PMS_WR;
      ST_PMS_WR:   nxt = ST_WAIT_LOCK;
      ST_WAIT_LOCK: begin
        if (pll_lock)     nxt = ST_WAIT_MAIN;
        else if (expired) abort = 1'b1;
      end
      ST_WAIT_MAIN: begin
        if (mux_stat == STAT_MAIN) step_done = 1'b1;
        else if (expired)          abort = 1'b1;
      end
      ST_FINISH:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
    if (step_done) begin
      // first step done: run the other kind; second done: finish or lower voltage
      if (!stage) nxt = step_entry(!up, full);
      else        nxt = up ? ST_FINISH : ST_VOLT;
    end
    if (abort) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= RST_LVL;
      tgt   <= RST_LVL;
      src   <= RST_LVL;
      up    <= 1'b0;
      stage <= 1'b0;
      mux_q <= 1'b0;
      err_q <= 1'b0;
      cfg_q <= lvl_word(RST_LVL);
      arm_q <= lvl_arm_mv(RST_LVL);
      int_q <= lvl_int_mv(RST_LVL);
    end else begin
      state <= nxt;
      if (state == ST_IDLE && req_valid) begin
        tgt   <= req_level;
        src   <= cur;
        up    <= (req_level < cur);
        stage <= 1'b0;
      end
      if (step_done && !stage) stage <= 1'b1;
      if (nxt == ST_VOLT && state != ST_VOLT) begin
        arm_q <= tab_arm;
        int_q <= tab_int;
      end
      if (nxt == ST_S_WR)   cfg_q[2:0] <= tab_post;
      if (nxt == ST_PMS_WR) cfg_q      <= tab_word;
      if (nxt == ST_WAIT_ALT && state != ST_WAIT_ALT)   mux_q <= 1'b1;
      if (nxt == ST_WAIT_MAIN && state != ST_WAIT_MAIN) mux_q <= 1'b0;
      if (state == ST_FINISH) cur <= tgt;
      if (abort) err_q <= 1'b1;
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign done        = (state == ST_FINISH);
  assign cur_level   = cur;
  assign err         = err_q;
  assign vset_valid  = (state == ST_VOLT);
  assign vset_arm_mv = arm_q;
  assign vset_int_mv = int_q;
  assign div_wr      = (state == ST_DIV_WR);
  assign div_level   = tgt;
  assign pll_cfg     = cfg_q;
  assign pll_wr      = (state == ST_PMS_WR) || (state == ST_S_WR);
  assign lt_wr       = (state == ST_LT_WR);
  assign lt_value    = LT_W'(LT_VAL);
  assign mux_alt     = mux_q;
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        err,
  input logic        vset_valid,
  input logic        vset_ready,
  input logic [10:0] vset_arm_mv,
  input logic [10:0] vset_int_mv,
  input logic [31:0] pll_cfg,
  input logic        lt_wr,
  input logic        mux_alt,
  input logic [2:0]  mux_stat
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R6
  vset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vset_valid && !vset_ready |=>
      (vset_valid && $stable(vset_arm_mv) && $stable(vset_int_mv)) || err);

  // R8
  mp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_cfg[25:8]) |-> mux_alt);

  // R7
  lt_on_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_wr |-> mux_alt && ($past(mux_stat) == 3'd2));

  // R10
  done_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mux_alt);
endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .err         (err),
  .vset_valid  (vset_valid),
  .vset_ready  (vset_ready),
  .vset_arm_mv (vset_arm_mv),
  .vset_int_mv (vset_int_mv),
  .pll_cfg     (pll_cfg),
  .lt_wr       (lt_wr),
  .mux_alt     (mux_alt),
  .mux_stat    (mux_stat)
);

// File: tb/dvfs_seq_test.sv
`timescale 1ns/1ps
module dvfs_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tmo_cycles = 8'd50;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_level = 2'd0;
  logic        done, err, vset_valid, vset_ready;
  logic [1:0]  cur_level, div_level;
  logic [10:0] vset_arm_mv, vset_int_mv;
  logic        div_wr, div_busy, pll_wr, lt_wr, pll_lock, mux_alt;
  logic [31:0] pll_cfg;
  logic [15:0] lt_value;
  logic [2:0]  mux_stat;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dvfs_seq #(.RST_LEVEL(3), .CNT_W(8), .LT_W(16), .LT_VAL(270)) uut (
    .clk(clk), .rst_n(rst_n), .tmo_cycles(tmo_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_level(req_level),
    .done(done), .cur_level(cur_level), .err(err),
    .vset_valid(vset_valid), .vset_ready(vset_ready),
    .vset_arm_mv(vset_arm_mv), .vset_int_mv(vset_int_mv),
    .div_wr(div_wr), .div_level(div_level), .div_busy(div_busy),
    .pll_cfg(pll_cfg), .pll_wr(pll_wr), .lt_wr(lt_wr), .lt_value(lt_value),
    .pll_lock(pll_lock), .mux_alt(mux_alt), .mux_stat(mux_stat)
  );

  // ---------------- responder models ----------------
  logic [2:0] vcnt, dcnt;
  logic [7:0] lcnt;
  logic [2:0] mpipe;
  logic       stuck = 1'b0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) vcnt <= '0;
    else        vcnt <= vset_valid ? vcnt + 3'd1 : 3'd0;
  assign vset_ready = vset_valid && (vcnt >= 3'd2);

  always @(posedge clk or negedge rst_n)
    if (!rst_n)             dcnt <= '0;
    else if (div_wr)        dcnt <= 3'd3;
    else if (dcnt != 3'd0)  dcnt <= dcnt - 3'd1;
  assign div_busy = (dcnt != 3'd0);

  always @(posedge clk or negedge rst_n)
    if (!rst_n)             lcnt <= '0;
    else if (pll_wr)        lcnt <= 8'd5;
    else if (lcnt != 8'd0)  lcnt <= lcnt - 8'd1;
  assign pll_lock = (lcnt == 8'd0) && !stuck;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mpipe <= '0;
    else        mpipe <= {mpipe[1:0], mux_alt};
  assign mux_stat = mpipe[2] ? 3'd2 : 3'd1;

  // ---------------- independent reference tables ----------------
  function automatic logic [31:0] ref_word(input logic [1:0] l);
    logic [9:0] m;
    logic [2:0] s;
    m = (l == 2'd0) ? 10'd250 : 10'd200;
    case (l)
      2'd0, 2'd1: s = 3'd1;
      2'd2:       s = 3'd2;
      default:    s = 3'd4;
    endcase
    return (32'(m) << 16) | (32'd6 << 8) | 32'(s);
  endfunction

  function automatic logic [10:0] ref_arm(input logic [1:0] l);
    case (l)
      2'd0: return 11'd1200;
      2'd1: return 11'd1100;
      2'd2: return 11'd1000;
      default: return 11'd900;
    endcase
  endfunction

  function automatic logic [10:0] ref_int(input logic [1:0] l);
    return (l <= 2'd1) ? 11'd1100 : 11'd1000;
  endfunction

  // ---------------- scoreboard ----------------
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic push(input logic [31:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic got(input logic [31:0] v);
    logic [31:0] e;
    string t;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R2 unexpected action", v, 32'hffff_ffff);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(v == e, t, v, e);
    end
  endtask

  logic mux_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (vset_valid && vset_ready) got({4'd1, 6'd0, vset_arm_mv, vset_int_mv});
      if (div_wr)                   got({4'd2, 26'd0, div_level});
      if (mux_alt && !mux_prev)     got({4'd3, 28'd0});
      if (lt_wr)                    got({4'd4, 12'd0, lt_value});
      if (pll_wr)                   got({4'd5, pll_cfg[27:0]});
      if (!mux_alt && mux_prev)     got({4'd6, 28'd0});
      if (done)                     got({4'd7, 28'd0});
      mux_prev = mux_alt;
    end
  end

  // ---------------- driver ----------------
  logic [1:0] model_lvl = 2'd3;

  task automatic push_pll(input logic [1:0] s, input logic [1:0] t);
    logic [31:0] w;
    if (s == 2'd0 || t == 2'd0) begin
      push({4'd3, 28'd0}, "R7 mux to alternate");
      push({4'd4, 12'd0, 16'd270}, "R7 lock time load");
      push({4'd5, ref_word(t)[27:0]}, "R9 full PLL word");
      push({4'd6, 28'd0}, "R7 mux back to main");
    end else begin
      w = {ref_word(s)[31:3], ref_word(t)[2:0]};
      push({4'd5, w[27:0]}, "R8 post-divider only");
    end
  endtask

  task automatic issue(input logic [1:0] t, input bit poke);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = t;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      req_valid = 1'b1;
      req_level = 2'd3;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!req_ready) @(negedge clk);
  endtask

  task automatic move(input logic [1:0] t, input bit poke);
    logic [1:0] s;
    logic [31:0] w_before;
    s = model_lvl;
    w_before = pll_cfg;
    if (t < s) begin
      push({4'd1, 6'd0, ref_arm(t), ref_int(t)}, "R4 raise voltage first R6");
      push({4'd2, 26'd0, t}, "R4 R12 divider write");
      push_pll(s, t);
    end else if (t > s) begin
      push_pll(s, t);
      push({4'd2, 26'd0, t}, "R5 R12 divider write");
      push({4'd1, 6'd0, ref_arm(t), ref_int(t)}, "R5 lower voltage last R6");
    end
    push({4'd7, 28'd0}, (t == s) ? "R3 immediate done" : "R10 done");
    issue(t, poke);
    model_lvl = t;
    chk(cur_level == t, poke ? "R2 level after ignored request" : "R10 cur_level", 32'(cur_level), 32'(t));
    chk(exp_q.size() == 0, "R4 R5 all actions seen", 32'(exp_q.size()), 32'd0);
    if (t == s)
      chk(pll_cfg == w_before, "R3 PLL word unchanged", pll_cfg, w_before);
    else
      chk(pll_cfg == ref_word(t), "R9 PLL word", pll_cfg, ref_word(t));
    chk({vset_arm_mv, vset_int_mv} == {ref_arm(t), ref_int(t)}, "R6 voltage outputs",
        32'({vset_arm_mv, vset_int_mv}), 32'({ref_arm(t), ref_int(t)}));
    chk(mux_alt == 1'b0, "R8 mux on main", 32'(mux_alt), 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !done && !err && !mux_alt && !vset_valid && !div_wr && !pll_wr && !lt_wr,
        "R1 idle flags", {26'd0, req_ready, done, err, mux_alt, vset_valid, div_wr}, 32'h20);
    chk(cur_level == 2'd3, "R1 cur_level", 32'(cur_level), 32'd3);
    chk(pll_cfg == ref_word(2'd3), "R1 PLL word", pll_cfg, ref_word(2'd3));
    chk({vset_arm_mv, vset_int_mv} == {ref_arm(2'd3), ref_int(2'd3)}, "R1 voltages",
        32'({vset_arm_mv, vset_int_mv}), 32'({ref_arm(2'd3), ref_int(2'd3)}));

    move(2'd3, 1'b0);   // R3 same level
    move(2'd2, 1'b0);   // R4 R8 faster, post-divider only
    move(2'd0, 1'b0);   // R4 R7 faster, relock
    move(2'd1, 1'b0);   // R5 R7 slower from L0
    move(2'd3, 1'b0);   // R5 R8 slower
    move(2'd1, 1'b0);   // R4 R8
    move(2'd0, 1'b0);   // R7
    move(2'd2, 1'b1);   // R2 request while busy ignored
    chk(err == 1'b0, "R11 no error before fault", 32'(err), 32'd0);

    // R11 stuck lock during relock 2 -> 0
    stuck = 1'b1;
    tmo_cycles = 8'd20;
    push({4'd1, 6'd0, ref_arm(2'd0), ref_int(2'd0)}, "R4 R11 voltage before fault");
    push({4'd2, 26'd0, 2'd0}, "R11 divider before fault");
    push({4'd3, 28'd0}, "R11 mux to alternate");
    push({4'd4, 12'd0, 16'd270}, "R11 lock time");
    push({4'd5, ref_word(2'd0)[27:0]}, "R11 PMS write");
    issue(2'd0, 1'b0);
    chk(err == 1'b1, "R11 error flag", 32'(err), 32'd1);
    chk(cur_level == 2'd2, "R11 level kept", 32'(cur_level), 32'd2);
    chk(exp_q.size() == 0, "R11 actions before abort", 32'(exp_q.size()), 32'd0);
    repeat (5) @(negedge clk);
    chk(err == 1'b1 && req_ready, "R11 sticky and idle", 32'({err, req_ready}), 32'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule